// File: doc/BRIEF.md
# Instruction cache parity checker

This block inspects the raw contents of one instruction-cache way and reports every parity bit that disagrees with the bits it protects. It receives the way's tag-high and tag-low words. It can also take the side words and the two instructions for each doubleword offset of the line. On a valid strobe the checks are evaluated, and one clock later a done pulse appears with per-check detail bits.

Two sticky summary flags collect results across strobes: one for the tag side and one for the data side. They stay set until a clear input is raised, so an error handler can step through all ways of a set and read one verdict at the end. Each side word protects three fields. The predecode byte has its own parity bit. Each instruction has a nibble of per-byte parity bits.

Top module: `icache_parity_chk`

## Requirements
- R1: While reset is low, and on the first cycle after it, done_o, both sticky flags and every detail bit read 0.
- R2: done_o is high for exactly the one cycle that follows a cycle with in_valid_i high. The detail outputs take the results of that strobe on the same edge and hold them until the next strobe.
- R3: If tag-high bit 29 (line valid) differs from tag-high bit 27 (its mirror), mirror_err_o and tag_err_o are set. This happens whatever the value of bit 29.
- R4: When tag-high bit 29 is 1, tag0_err_o is set if tag-low bit 10 differs from the XOR of tag-low bits 23..12 and 9..0.
- R5: When tag-high bit 29 is 1, tag1_err_o is set if tag-low bit 11 differs from the XOR of tag-low bits 63..24.
- R6: When tag-high bit 29 is 0, tag0_err_o and tag1_err_o read 0 and the tag-low word cannot set tag_err_o.
- R7: Offset k's side word is side_i[17k+16 : 17k]. Its bit 16 must equal the XOR of its bits 15..8 (the predecode byte). A mismatch sets pdec_err_o[k].
- R8: Side-word bits 7..4 carry the parity of instruction A (insta_i[32k+31 : 32k]), and bits 3..0 carry the parity of instruction B. Nibble bit j is the XOR of instruction byte j, so the most significant byte maps to the most significant nibble bit. Any mismatch sets insta_err_o[k] or instb_err_o[k].
- R9: When data_en_i is 0 during a strobe, all data detail bits read 0 and data_err_o is not set by that strobe.
- R10: tag_err_o and data_err_o stay set until clr_i is sampled high. If clr_i and a strobe that finds an error occur in the same cycle, the flag ends up set.
- R11: A parity failure at any one of the four offsets sets data_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clears both sticky flags |
| in_valid_i | input | 1 | Strobe: check the presented way |
| data_en_i | input | 1 | Also check the data side words |
| tag_hi_i | input | 32 | Tag-high word (valid bit 29, mirror bit 27) |
| tag_lo_i | input | 64 | Tag-low word (parity bits 11 and 10) |
| side_i | input | 68 | Four 17-bit side words, offset k at 17k |
| insta_i | input | 128 | Four instruction-A words, offset k at 32k |
| instb_i | input | 128 | Four instruction-B words, offset k at 32k |
| done_o | output | 1 | One-cycle pulse after each strobe |
| tag_err_o | output | 1 | Sticky tag-parity flag |
| data_err_o | output | 1 | Sticky data-parity flag |
| mirror_err_o | output | 1 | Valid-bit mirror mismatch of last strobe |
| tag0_err_o | output | 1 | Low tag-range parity failure of last strobe |
| tag1_err_o | output | 1 | High tag-range parity failure of last strobe |
| pdec_err_o | output | 4 | Predecode parity failure per offset |
| insta_err_o | output | 4 | Instruction-A byte parity failure per offset |
| instb_err_o | output | 4 | Instruction-B byte parity failure per offset |

## Verification
A wrong bit range or wrong bit order in any parity group causes a detail bit that should be clear to be set, or the reverse. This shows up on the done cycle of the strobe that carries a single flipped bit. A lost or stuck sticky flag shows on the first strobe or clear after the fault, because every strobe compares both flags against a running model. Missing data gating or validity gating appears on the same cycle as the strobe that is meant to be ignored.

// File: rtl/icpc_pkg.sv
package icpc_pkg;

    localparam int TAG_HI_W   = 32;
    localparam int TAG_LO_W   = 64;
    localparam int VLD_BIT    = 29;
    localparam int VLD_MIRROR = 27;
    localparam int TP0_BIT    = 10;
    localparam int TP1_BIT    = 11;
    localparam int TP0_TOP    = 23;
    localparam int TP1_LOW    = 24;

    typedef struct packed {
        logic mirror;
        logic lo_range;
        logic hi_range;
    } tag_res_t;

endpackage

// File: rtl/icpc_tag_chk.sv
module icpc_tag_chk
    import icpc_pkg::*;
(
    input  logic [TAG_HI_W-1:0] tag_hi_i,
    input  logic [TAG_LO_W-1:0] tag_lo_i,
    output tag_res_t            res_o
);
    logic line_vld;
    logic lo_xor;
    logic hi_xor;
    logic [TP0_TOP:0] lo_masked;

    always_comb begin
        line_vld  = tag_hi_i[VLD_BIT];
        lo_masked = tag_lo_i[TP0_TOP:0];
        lo_masked[TP0_BIT] = 1'b0;
        lo_masked[TP1_BIT] = 1'b0;
        lo_xor    = ^lo_masked;
        hi_xor    = ^tag_lo_i[TAG_LO_W-1:TP1_LOW];

        res_o.mirror   = tag_hi_i[VLD_BIT] ^ tag_hi_i[VLD_MIRROR];
        res_o.lo_range = line_vld & (tag_lo_i[TP0_BIT] ^ lo_xor);
        res_o.hi_range = line_vld & (tag_lo_i[TP1_BIT] ^ hi_xor);
    end

endmodule

// File: rtl/icpc_data_lane.sv
module icpc_data_lane #(
    parameter int INST_W = 32,
    parameter int PDEC_W = 8,
    localparam int NIB    = INST_W / 8,
    localparam int SIDE_W = 1 + PDEC_W + 2 * NIB
) (
    input  logic              en_i,
    input  logic [SIDE_W-1:0] side_i,
    input  logic [INST_W-1:0] insta_i,
    input  logic [INST_W-1:0] instb_i,
    output logic              pdec_err_o,
    output logic              a_err_o,
    output logic              b_err_o
);
    localparam int PAR_POS  = 2 * NIB + PDEC_W;
    localparam int PDEC_POS = 2 * NIB;
    localparam int A_POS    = NIB;

    function automatic logic [NIB-1:0] byte_par(input logic [INST_W-1:0] w);
        logic [NIB-1:0] r;
        for (int b = 0; b < NIB; b++) begin
            r[b] = ^w[b*8 +: 8];
        end
        return r;
    endfunction

    always_comb begin
        pdec_err_o = en_i & (side_i[PAR_POS] ^ (^side_i[PDEC_POS +: PDEC_W]));
        a_err_o    = en_i & (side_i[A_POS +: NIB] != byte_par(insta_i));
        b_err_o    = en_i & (side_i[0 +: NIB] != byte_par(instb_i));
    end

endmodule

// File: rtl/icache_parity_chk.sv
module icache_parity_chk
    import icpc_pkg::*;
#(
    parameter int NUM_OFFS = 4,
    parameter int INST_W   = 32,
    parameter int PDEC_W   = 8,
    localparam int NIB     = INST_W / 8,
    localparam int SIDE_W  = 1 + PDEC_W + 2 * NIB
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       clr_i,
    input  logic                       in_valid_i,
    input  logic                       data_en_i,
    input  logic [TAG_HI_W-1:0]        tag_hi_i,
    input  logic [TAG_LO_W-1:0]        tag_lo_i,
    input  logic [NUM_OFFS*SIDE_W-1:0] side_i,
    input  logic [NUM_OFFS*INST_W-1:0] insta_i,
    input  logic [NUM_OFFS*INST_W-1:0] instb_i,
    output logic                       done_o,
    output logic                       tag_err_o,
    output logic                       data_err_o,
    output logic                       mirror_err_o,
    output logic                       tag0_err_o,
    output logic                       tag1_err_o,
    output logic [NUM_OFFS-1:0]        pdec_err_o,
    output logic [NUM_OFFS-1:0]        insta_err_o,
    output logic [NUM_OFFS-1:0]        instb_err_o
);

    typedef struct packed {
        logic                done;
        logic                tag_flag;
        logic                data_flag;
        tag_res_t            tag;
        logic [NUM_OFFS-1:0] pdec;
        logic [NUM_OFFS-1:0] ia;
        logic [NUM_OFFS-1:0] ib;
    } state_t;

    state_t   st_d, st_q;
    tag_res_t tag_res;
    logic [NUM_OFFS-1:0] pdec_c, ia_c, ib_c;

    icpc_tag_chk u_tag (
        .tag_hi_i (tag_hi_i),
        .tag_lo_i (tag_lo_i),
        .res_o    (tag_res)
    );

    for (genvar k = 0; k < NUM_OFFS; k++) begin : g_lane
        icpc_data_lane #(
            .INST_W (INST_W),
            .PDEC_W (PDEC_W)
        ) u_lane (
            .en_i       (data_en_i),
            .side_i     (side_i[k*SIDE_W +: SIDE_W]),
            .insta_i    (insta_i[k*INST_W +: INST_W]),
            .instb_i    (instb_i[k*INST_W +: INST_W]),
            .pdec_err_o (pdec_c[k]),
            .a_err_o    (ia_c[k]),
            .b_err_o    (ib_c[k])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = in_valid_i;
        if (clr_i) begin
            st_d.tag_flag  = 1'b0;
            st_d.data_flag = 1'b0;
        end
        if (in_valid_i) begin
            st_d.tag  = tag_res;
            st_d.pdec = pdec_c;
            st_d.ia   = ia_c;
            st_d.ib   = ib_c;
            if (|tag_res) begin
                st_d.tag_flag = 1'b1;
            end
            if (|{pdec_c, ia_c, ib_c}) begin
                st_d.data_flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o       = st_q.done;
    assign tag_err_o    = st_q.tag_flag;
    assign data_err_o   = st_q.data_flag;
    assign mirror_err_o = st_q.tag.mirror;
    assign tag0_err_o   = st_q.tag.lo_range;
    assign tag1_err_o   = st_q.tag.hi_range;
    assign pdec_err_o   = st_q.pdec;
    assign insta_err_o  = st_q.ia;
    assign instb_err_o  = st_q.ib;

endmodule

// File: rtl/icache_parity_chk_sva.sv
module icache_parity_chk_sva #(
    parameter int NUM_OFFS = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                clr_i,
    input logic                in_valid_i,
    input logic                data_en_i,
    input logic [31:0]         tag_hi_i,
    input logic                done_o,
    input logic                tag_err_o,
    input logic                data_err_o,
    input logic                mirror_err_o,
    input logic                tag0_err_o,
    input logic                tag1_err_o,
    input logic [NUM_OFFS-1:0] pdec_err_o,
    input logic [NUM_OFFS-1:0] insta_err_o,
    input logic [NUM_OFFS-1:0] instb_err_o
);

    p_done_after_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> done_o);

    p_no_spurious_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !done_o);

    p_mirror_sets_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (tag_hi_i[29] != tag_hi_i[27])) |=> (mirror_err_o && tag_err_o));

    p_invalid_line_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && !tag_hi_i[29]) |=> (!tag0_err_o && !tag1_err_o));

    p_data_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && !data_en_i) |=> (pdec_err_o == '0 && insta_err_o == '0 && instb_err_o == '0));

    p_tag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tag_err_o && !clr_i) |=> tag_err_o);

    p_data_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_err_o && !clr_i) |=> data_err_o);

    p_clear_alone_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !in_valid_i) |=> (!tag_err_o && !data_err_o));

    p_any_offset_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && |{pdec_err_o, insta_err_o, instb_err_o}) |-> data_err_o);

endmodule

bind icache_parity_chk icache_parity_chk_sva #(.NUM_OFFS(NUM_OFFS)) u_sva (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr_i),
    .in_valid_i   (in_valid_i),
    .data_en_i    (data_en_i),
    .tag_hi_i     (tag_hi_i),
    .done_o       (done_o),
    .tag_err_o    (tag_err_o),
    .data_err_o   (data_err_o),
    .mirror_err_o (mirror_err_o),
    .tag0_err_o   (tag0_err_o),
    .tag1_err_o   (tag1_err_o),
    .pdec_err_o   (pdec_err_o),
    .insta_err_o  (insta_err_o),
    .instb_err_o  (instb_err_o)
);

// File: tb/icache_parity_chk_tb_top.sv
module icache_parity_chk_tb_top;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         clr_i = 1'b0;
    logic         in_valid_i = 1'b0;
    logic         data_en_i = 1'b0;
    logic [31:0]  tag_hi_i = '0;
    logic [63:0]  tag_lo_i = '0;
    logic [67:0]  side_i = '0;
    logic [127:0] insta_i = '0;
    logic [127:0] instb_i = '0;
    logic         done_o, tag_err_o, data_err_o, mirror_err_o, tag0_err_o, tag1_err_o;
    logic [3:0]   pdec_err_o, insta_err_o, instb_err_o;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_tflag = 1'b0;
    logic exp_dflag = 1'b0;
    bit   finished = 1'b0;

    always #4 clk_i = ~clk_i;

    icache_parity_chk dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] m_nib(input logic [31:0] w);
        logic [3:0] r = '0;
        for (int i = 0; i < 32; i++) r[i/8] = r[i/8] ^ w[i];
        return r;
    endfunction

    function automatic logic m_t0(input logic [63:0] t);
        logic p = 1'b0;
        for (int i = 0; i <= 23; i++) if (i != 10 && i != 11) p = p ^ t[i];
        return p ^ t[10];
    endfunction

    function automatic logic m_t1(input logic [63:0] t);
        logic p = 1'b0;
        for (int i = 24; i < 64; i++) p = p ^ t[i];
        return p ^ t[11];
    endfunction

    function automatic logic m_pd(input logic [16:0] s);
        logic p = 1'b0;
        for (int i = 8; i < 16; i++) p = p ^ s[i];
        return p ^ s[16];
    endfunction

    function automatic logic [63:0] fix_tag_lo(input logic [63:0] t);
        logic [63:0] r = t;
        r[10] = 1'b0; r[11] = 1'b0;
        r[10] = m_t0(r);
        r[11] = m_t1(r);
        return r;
    endfunction

    function automatic logic [16:0] fix_side(input logic [7:0] pd, input logic [31:0] a, input logic [31:0] b);
        logic p = 1'b0;
        for (int i = 0; i < 8; i++) p = p ^ pd[i];
        return {p, pd, m_nib(a), m_nib(b)};
    endfunction

    task automatic make_clean(input bit vld);
        tag_lo_i = fix_tag_lo({$urandom, $urandom});
        tag_hi_i = $urandom;
        tag_hi_i[29] = vld;
        tag_hi_i[27] = vld;
        for (int k = 0; k < 4; k++) begin
            insta_i[k*32 +: 32] = $urandom;
            instb_i[k*32 +: 32] = $urandom;
            side_i[k*17 +: 17]  = fix_side(8'($urandom), insta_i[k*32 +: 32], instb_i[k*32 +: 32]);
        end
    endtask

    // drive one strobe at the falling edge, check after the next rising edge
    task automatic strobe(input string tag, input bit den, input bit clr);
        logic       e_m, e_0, e_1;
        logic [3:0] e_pd, e_a, e_b;
        e_m = tag_hi_i[29] ^ tag_hi_i[27];
        e_0 = tag_hi_i[29] & m_t0(tag_lo_i);
        e_1 = tag_hi_i[29] & m_t1(tag_lo_i);
        for (int k = 0; k < 4; k++) begin
            e_pd[k] = den & m_pd(side_i[k*17 +: 17]);
            e_a[k]  = den & (side_i[k*17+4 +: 4] != m_nib(insta_i[k*32 +: 32]));
            e_b[k]  = den & (side_i[k*17 +: 4] != m_nib(instb_i[k*32 +: 32]));
        end
        if (clr) begin exp_tflag = 1'b0; exp_dflag = 1'b0; end
        if (e_m | e_0 | e_1) exp_tflag = 1'b1;
        if (|{e_pd, e_a, e_b}) exp_dflag = 1'b1;
        data_en_i  = den;
        clr_i      = clr;
        in_valid_i = 1'b1;
        @(negedge clk_i);
        in_valid_i = 1'b0;
        clr_i      = 1'b0;
        chk({tag, " R2 done"}, 32'(done_o), 32'd1);
        chk({tag, " R3 mirror"}, 32'(mirror_err_o), 32'(e_m));
        chk({tag, " R4 tag0"}, 32'(tag0_err_o), 32'(e_0));
        chk({tag, " R5 tag1"}, 32'(tag1_err_o), 32'(e_1));
        chk({tag, " R7 predecode"}, 32'(pdec_err_o), 32'(e_pd));
        chk({tag, " R8 inst A/B"}, 32'({insta_err_o, instb_err_o}), 32'({e_a, e_b}));
        chk({tag, " R10 tag flag"}, 32'(tag_err_o), 32'(exp_tflag));
        chk({tag, " R11 data flag"}, 32'(data_err_o), 32'(exp_dflag));
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk_i);
        chk({tag, " R2 done idle"}, 32'(done_o), 32'd0);
        chk({tag, " R10 flags hold"}, 32'({tag_err_o, data_err_o}), 32'({exp_tflag, exp_dflag}));
    endtask

    task automatic clear_only();
        clr_i = 1'b1;
        @(negedge clk_i);
        clr_i = 1'b0;
        exp_tflag = 1'b0;
        exp_dflag = 1'b0;
        chk("R10 clear", 32'({tag_err_o, data_err_o}), 32'd0);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        @(negedge clk_i);
        @(negedge clk_i);
        chk("R1 reset outputs", 32'({done_o, tag_err_o, data_err_o, mirror_err_o, tag0_err_o,
            tag1_err_o, pdec_err_o, insta_err_o, instb_err_o}), 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1 after reset", 32'({done_o, tag_err_o, data_err_o}), 32'd0);

        // clean valid line with data
        make_clean(1'b1);
        strobe("clean", 1'b1, 1'b0);
        idle_check("clean");

        // R6: invalid line, broken tag-low parity ignored
        make_clean(1'b0);
        tag_lo_i[10] = ~tag_lo_i[10];
        tag_lo_i[40] = ~tag_lo_i[40];
        strobe("R6 invalid line", 1'b0, 1'b0);
        chk("R6 no tag flag", 32'(tag_err_o), 32'd0);

        // R3: mirror mismatch with line invalid
        make_clean(1'b0);
        tag_hi_i[27] = 1'b1;
        strobe("R3 invalid mirror", 1'b0, 1'b0);
        idle_check("R3 sticky");
        clear_only();

        // R4 masking: bits 11 and 10 themselves excluded from the low range
        make_clean(1'b1);
        tag_lo_i[11] = ~tag_lo_i[11];
        strobe("R4 mask bit11", 1'b0, 1'b0);
        clear_only();

        // R9: bad data with checks disabled
        make_clean(1'b1);
        side_i[16] = ~side_i[16];
        insta_i[31] = ~insta_i[31];
        strobe("R9 data disabled", 1'b0, 1'b0);
        chk("R9 data flag stays clear", 32'(data_err_o), 32'd0);

        // R11: error only at last offset; R8 MSB byte mapping
        make_clean(1'b1);
        side_i[3*17 + 7] = ~side_i[3*17 + 7];
        strobe("R11 offset3 A msb", 1'b1, 1'b0);
        chk("R8 A msb offset3", 32'(insta_err_o), 32'h8);

        // R10: clear with simultaneous error keeps the flag set
        make_clean(1'b1);
        instb_i[0] = ~instb_i[0];
        strobe("R10 clr+err", 1'b1, 1'b1);
        clear_only();
        make_clean(1'b1);
        strobe("R10 clr+clean", 1'b1, 1'b1);

        // random single-bit injections
        for (int it = 0; it < 400; it++) begin
            int kind, k;
            make_clean($urandom_range(0, 3) != 0);
            kind = $urandom_range(0, 7);
            k = $urandom_range(0, 3);
            case (kind)
                1: tag_hi_i[29] = ~tag_hi_i[29];
                2: tag_hi_i[27] = ~tag_hi_i[27];
                3: tag_lo_i[$urandom_range(0, 23)] ^= 1'b1;
                4: tag_lo_i[$urandom_range(24, 63)] ^= 1'b1;
                5: side_i[k*17 + $urandom_range(0, 16)] ^= 1'b1;
                6: insta_i[k*32 + $urandom_range(0, 31)] ^= 1'b1;
                7: instb_i[k*32 + $urandom_range(0, 31)] ^= 1'b1;
                default: ;
            endcase
            strobe($sformatf("rand%0d kind%0d", it, kind), $urandom_range(0, 3) != 0,
                   $urandom_range(0, 5) == 0);
            if ($urandom_range(0, 3) == 0) idle_check("rand idle");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule